// File: doc/BRIEF.md
# Transmit Interrupt Delay Timer

This block postpones the transmit-complete interrupt of a network transmit engine. Each time the engine writes back a finished descriptor it presents a one-cycle event strobe with two flags: one asking for completion to be reported, and one asking for that report to be delayed. A reported, delayed completion arms a countdown with a software-programmed delay. The countdown moves only on a slow timebase tick. When it runs out, an interrupt request is raised.

Each further delayed completion restarts the countdown from the full delay value. A burst of completions therefore produces a single interrupt, issued one delay after the last completion of the burst. A completion that asks for a report without delay raises the interrupt at once and abandons any countdown in progress. The interrupt request is sticky until software clears it.

Top module: `txIntDelayTimer`

## Requirements
- R1: After reset `irqOut` is 0, no countdown is running and the delay register holds `RESET_DELAY` (default 0).
- R2: When `cfgWrEn` is high, the delay register takes `cfgWrData` at that clock edge. An event sampled in the same cycle as the write uses the previous delay value.
- R3: An event with `wbValid`=1, `wbReportStatus`=1, `wbDelayEnable`=1 and delay D>0 loads a countdown of D. `irqOut` becomes 1 in the cycle after the edge that samples the D-th `tick`, and not earlier.
- R4: The countdown advances only on cycles where `tick` is 1. Cycles without a tick leave it unchanged.
- R5: A qualifying event while a countdown is running reloads it to the full delay value, so the interrupt moves later.
- R6: An event with `wbReportStatus`=1 and `wbDelayEnable`=0 sets `irqOut` in the next cycle and cancels any running countdown. The cancelled countdown never fires.
- R7: With a delay value of 0, a qualifying event sets `irqOut` in the next cycle and starts no countdown.
- R8: An event with `wbReportStatus`=0 is ignored. It neither loads, fires nor disturbs a running countdown.
- R9: `irqOut` stays 1 until `irqClear`, which drops it in the next cycle. A set condition in the same cycle as `irqClear` wins.
- R10: A qualifying event in the same cycle as the expiring tick takes priority. No interrupt is raised and the countdown restarts at the delay value.
- R11: A `tick` while no countdown is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wbValid | input | 1 | Descriptor write-back event strobe |
| wbReportStatus | input | 1 | Event asks for completion to be reported |
| wbDelayEnable | input | 1 | Event asks for the report to be delayed |
| cfgWrEn | input | 1 | Write enable for the delay register |
| cfgWrData | input | DELAY_W | New delay value in ticks |
| tick | input | 1 | Timebase tick, one cycle wide |
| irqClear | input | 1 | Clears the interrupt request |
| irqOut | output | 1 | Sticky transmit interrupt request |

## Verification
A wrong counter value or a lost running flag shows only as `irqOut` rising at the wrong tick. The fault appears one delay period after the arming event, or never appears at all. The checks therefore count ticks exactly and sample `irqOut` both before and right after the expected expiry edge. A fault in reload or cancel priority is otherwise hidden until the next expiry, so those scenarios keep ticking past the old deadline. A corrupted delay register shows up at the next arming event as an early or late interrupt.

// File: rtl/txIntDelayPkg.sv
package txIntDelayPkg;
  typedef struct packed {
    logic load;
    logic dec;
  } tidStrobes_t;
endpackage

// File: rtl/txIntDelayDatapath.sv
module txIntDelayDatapath
  import txIntDelayPkg::*;
#(
  parameter int DELAY_W     = 16,
  parameter int RESET_DELAY = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [DELAY_W-1:0] cfgWrData,
  input  tidStrobes_t        strobes,
  output logic [DELAY_W-1:0] delayValue,
  output logic [DELAY_W-1:0] countValue,
  output logic               delayIsZero,
  output logic               countIsOne
);
  localparam logic [DELAY_W-1:0] ResetVal = DELAY_W'(RESET_DELAY);
  localparam logic [DELAY_W-1:0] One      = DELAY_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayValue <= ResetVal;
    end else if (cfgWrEn) begin
      delayValue <= cfgWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countValue <= '0;
    end else if (strobes.load) begin
      countValue <= delayValue;
    end else if (strobes.dec) begin
      countValue <= countValue - One;
    end
  end

  assign delayIsZero = (delayValue == '0);
  assign countIsOne  = (countValue == One);
endmodule

// File: rtl/txIntDelayControl.sv
module txIntDelayControl
  import txIntDelayPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wbValid,
  input  logic        wbReportStatus,
  input  logic        wbDelayEnable,
  input  logic        tick,
  input  logic        irqClear,
  input  logic        delayIsZero,
  input  logic        countIsOne,
  output tidStrobes_t strobes,
  output logic        countRunning,
  output logic        irqOut
);
  logic armEvent, directEvent, armLoad, armZero, expire, irqSet;

  assign armEvent    = wbValid & wbReportStatus & wbDelayEnable;
  assign directEvent = wbValid & wbReportStatus & ~wbDelayEnable;
  assign armLoad     = armEvent & ~delayIsZero;
  assign armZero     = armEvent & delayIsZero;
  assign expire      = countRunning & tick & countIsOne & ~armEvent;
  assign irqSet      = directEvent | armZero | expire;

  always_comb begin
    strobes.load = armLoad;
    strobes.dec  = countRunning & tick & ~armEvent;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countRunning <= 1'b0;
    end else if (armLoad) begin
      countRunning <= 1'b1;
    end else if (directEvent | armZero | expire) begin
      countRunning <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut <= 1'b0;
    end else if (irqSet) begin
      irqOut <= 1'b1;
    end else if (irqClear) begin
      irqOut <= 1'b0;
    end
  end
endmodule

// File: rtl/txIntDelayTimer.sv
module txIntDelayTimer
  import txIntDelayPkg::*;
#(
  parameter int DELAY_W     = 16,
  parameter int RESET_DELAY = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wbValid,
  input  logic               wbReportStatus,
  input  logic               wbDelayEnable,
  input  logic               cfgWrEn,
  input  logic [DELAY_W-1:0] cfgWrData,
  input  logic               tick,
  input  logic               irqClear,
  output logic               irqOut
);
  tidStrobes_t        strobes;
  logic [DELAY_W-1:0] delayValue;
  logic [DELAY_W-1:0] countValue;
  logic               delayIsZero;
  logic               countIsOne;
  logic               countRunning;

  txIntDelayDatapath #(
    .DELAY_W    (DELAY_W),
    .RESET_DELAY(RESET_DELAY)
  ) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .strobes    (strobes),
    .delayValue (delayValue),
    .countValue (countValue),
    .delayIsZero(delayIsZero),
    .countIsOne (countIsOne)
  );

  txIntDelayControl control_i (
    .clk           (clk),
    .rstN          (rstN),
    .wbValid       (wbValid),
    .wbReportStatus(wbReportStatus),
    .wbDelayEnable (wbDelayEnable),
    .tick          (tick),
    .irqClear      (irqClear),
    .delayIsZero   (delayIsZero),
    .countIsOne    (countIsOne),
    .strobes       (strobes),
    .countRunning  (countRunning),
    .irqOut        (irqOut)
  );
endmodule

// File: rtl/txIntDelayTimer_chk.sv
module txIntDelayTimer_chk #(
  parameter int DELAY_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               wbValid,
  input logic               wbReportStatus,
  input logic               wbDelayEnable,
  input logic               tick,
  input logic               irqClear,
  input logic               irqOut,
  input logic               countRunning,
  input logic [DELAY_W-1:0] countValue,
  input logic [DELAY_W-1:0] delayValue
);
  logic armEv, anyRs;
  assign armEv = wbValid && wbReportStatus && wbDelayEnable;
  assign anyRs = wbValid && wbReportStatus;

  // R3 / R6 / R7: a rise needs a reporting event or a tick in the previous cycle.
  assert_rise_has_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(anyRs || tick));

  // R3: a qualifying event with a non-zero delay arms the full delay.
  assert_arm_loads_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armEv && delayValue != '0) |=> (countRunning && countValue == $past(delayValue)));

  // R4: a tick that neither expires nor reloads takes exactly one off the count.
  assert_tick_decrements_R4: assert property (@(posedge clk) disable iff (!rstN)
    (countRunning && tick && !anyRs && countValue != DELAY_W'(1))
      |=> (countValue == $past(countValue) - DELAY_W'(1)));

  // R4: with no tick and no event, the count holds.
  assert_no_tick_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !anyRs) |=> $stable(countValue));

  // R6: an undelayed report fires and cancels the countdown.
  assert_direct_fire_R6: assert property (@(posedge clk) disable iff (!rstN)
    (anyRs && !wbDelayEnable) |=> (irqOut && !countRunning));

  // R9: the request is sticky without a clear.
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !irqClear) |=> irqOut);

  // R9: a clear with no competing cause drops the request.
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear && !anyRs && !tick) |=> !irqOut);
endmodule

bind txIntDelayTimer txIntDelayTimer_chk #(.DELAY_W(DELAY_W)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .wbValid       (wbValid),
  .wbReportStatus(wbReportStatus),
  .wbDelayEnable (wbDelayEnable),
  .tick          (tick),
  .irqClear      (irqClear),
  .irqOut        (irqOut),
  .countRunning  (countRunning),
  .countValue    (countValue),
  .delayValue    (delayValue)
);

// File: tb/txIntDelayTimer_tb_top.sv
module txIntDelayTimer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wbValid = 1'b0, wbReportStatus = 1'b0, wbDelayEnable = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [DW-1:0] cfgWrData = '0;
  logic tick = 1'b0, irqClear = 1'b0;
  logic irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txIntDelayTimer #(.DELAY_W(DW), .RESET_DELAY(0)) dut_i (
    .clk(clk), .rstN(rstN), .wbValid(wbValid), .wbReportStatus(wbReportStatus),
    .wbDelayEnable(wbDelayEnable), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .tick(tick), .irqClear(irqClear), .irqOut(irqOut)
  );

  task automatic expectIrq(input logic exp, input string req, input string what);
    total++;
    if (irqOut !== exp) begin
      bad++;
      $display("FAIL %s %s: irqOut actual=%0b expected=%0b", req, what, irqOut, exp);
    end
  endtask

  // One clock cycle of stimulus, applied and released on falling edges.
  task automatic cyc(input logic v, input logic rs, input logic ide, input logic tk,
                     input logic clr, input logic we, input logic [DW-1:0] d);
    wbValid = v; wbReportStatus = rs; wbDelayEnable = ide; tick = tk;
    irqClear = clr; cfgWrEn = we; cfgWrData = d;
    @(posedge clk);
    @(negedge clk);
    wbValid = 0; wbReportStatus = 0; wbDelayEnable = 0; tick = 0;
    irqClear = 0; cfgWrEn = 0; cfgWrData = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, '0);
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 0, 0, '0);
  endtask
  task automatic arm();      cyc(1, 1, 1, 0, 0, 0, '0); endtask
  task automatic clearIrq(); cyc(0, 0, 0, 0, 1, 0, '0); endtask
  task automatic setDelay(input logic [DW-1:0] d); cyc(0, 0, 0, 0, 0, 1, d); endtask

  task automatic testResetAndZeroDelay();
    expectIrq(0, "R1", "after reset");
    ticks(3);
    expectIrq(0, "R11", "ticks while idle after reset");
    arm();
    expectIrq(1, "R7", "reset delay 0 fires next cycle");
    expectIrq(1, "R1", "reset delay register is 0");
    clearIrq();
    expectIrq(0, "R9", "clear drops request");
    ticks(3);
    expectIrq(0, "R7", "no countdown started by zero delay");
  endtask

  task automatic testBasicCountdown();
    setDelay(3);
    arm();
    expectIrq(0, "R3", "armed, no tick yet");
    idle(5);
    expectIrq(0, "R4", "no ticks, no progress");
    ticks(2);
    expectIrq(0, "R3", "two of three ticks");
    ticks(1);
    expectIrq(1, "R3", "third tick expires");
    clearIrq();
    ticks(4);
    expectIrq(0, "R11", "expired countdown does not refire");
  endtask

  task automatic testWriteSameCycle();
    setDelay(3);
    cyc(1, 1, 1, 0, 0, 1, 16'd5);
    ticks(2);
    expectIrq(0, "R2", "old delay 3, two ticks");
    ticks(1);
    expectIrq(1, "R2", "event used old delay 3");
    clearIrq();
    arm();
    ticks(4);
    expectIrq(0, "R2", "new delay 5, four ticks");
    ticks(1);
    expectIrq(1, "R2", "new delay 5 applied");
    clearIrq();
  endtask

  task automatic testReload();
    setDelay(3);
    arm();
    ticks(2);
    arm();
    ticks(2);
    expectIrq(0, "R5", "reload pushed expiry later");
    ticks(1);
    expectIrq(1, "R5", "fires three ticks after reload");
    clearIrq();
  endtask

  task automatic testDirectReport();
    setDelay(4);
    arm();
    ticks(1);
    cyc(1, 1, 0, 0, 0, 0, '0);
    expectIrq(1, "R6", "undelayed report fires next cycle");
    clearIrq();
    ticks(5);
    expectIrq(0, "R6", "cancelled countdown never fires");
  endtask

  task automatic testNoReport();
    setDelay(3);
    cyc(1, 0, 1, 0, 0, 0, '0);
    ticks(4);
    expectIrq(0, "R8", "event without report ignored when idle");
    arm();
    ticks(1);
    cyc(1, 0, 1, 0, 0, 0, '0);
    ticks(1);
    expectIrq(0, "R8", "two ticks after arm");
    ticks(1);
    expectIrq(1, "R8", "unreported event did not reload");
    clearIrq();
    cyc(1, 0, 0, 0, 0, 0, '0);
    expectIrq(0, "R8", "unreported undelayed event ignored");
  endtask

  task automatic testSticky();
    cyc(1, 1, 0, 0, 0, 0, '0);
    idle(4);
    expectIrq(1, "R9", "request held without clear");
    cyc(1, 1, 0, 0, 1, 0, '0);
    expectIrq(1, "R9", "set wins over clear");
    clearIrq();
    expectIrq(0, "R9", "clear after sticky");
  endtask

  task automatic testReloadAtExpiry();
    setDelay(2);
    arm();
    ticks(1);
    cyc(1, 1, 1, 1, 0, 0, '0);
    expectIrq(0, "R10", "reload on expiring tick suppresses fire");
    ticks(1);
    expectIrq(0, "R10", "restarted count one tick");
    ticks(1);
    expectIrq(1, "R10", "restarted count expires");
    clearIrq();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testResetAndZeroDelay();
    testBasicCountdown();
    testWriteSameCycle();
    testReload();
    testDirectReport();
    testNoReport();
    testSticky();
    testReloadAtExpiry();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule